// File: doc/BRIEF.md
# Programmable Odd/Even Clock Divider

This block divides an incoming oscillator clock by a programmable integer between 2 and 16. Its output duty cycle stays at 50 percent for both even and odd divide ratios. A small select word chooses the ratio. The zero code switches the divided clock off and parks it low, which stops all toggling on the output side.

The divider counts rising edges of the source clock. For an odd ratio it also keeps a copy of its high phase registered on the falling edge. That copy stretches the high time by half a source period, so the high and low times come out equal. Two identical copies of the result leave the block for separate loads.

A new select value is taken only when the current output period ends, so the output never carries a shortened or runt pulse. A status bit reports whether the output is running.

Top module: `clkdiv_oddeven`

## Requirements
- R1: A nonzero select code n gives an output period of exactly n+1 source clock cycles. Codes 1 to 15 give ratios 2 to 16.
- R2: For an even ratio N, the output goes high on a source rising edge and stays high for N/2 source cycles. The high time is N half-periods of the source clock.
- R3: For an odd ratio N, the output rises on a source rising edge and falls on a source falling edge. Its high time is N half-periods of the source clock, which is (N-1)/2 full cycles plus one half cycle.
- R4: Select code 0 holds both outputs low and holds the status bit `out_en` at 0 for as long as the code stays 0.
- R5: `out_en` reads 1 whenever a nonzero code is in effect.
- R6: A change of select code takes effect only at the end of the output period in progress. The period that is running finishes with the ratio it started with.
- R7: `clk_out_a` and `clk_out_b` always carry the same level.
- R8: While `rst` is high at rising edges, both outputs are low and `out_en` is 0. The select input is ignored during that time.
- R9: When the divider is off, either after reset or under code 0, a nonzero code is loaded at the next rising edge. The output goes high and `out_en` goes to 1 right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Source clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| div_sel | input | SEL_W (4) | Ratio select: 0 = off, n = divide by n+1 |
| clk_out_a | output | 1 | Divided clock, copy A |
| clk_out_b | output | 1 | Divided clock, copy B |
| out_en | output | 1 | 1 while a divided clock is being produced |

## Verification
The status bit and the first high level both appear just after the rising edge that loads a code, one edge after the divider was off. The bench checks them at a quarter period past that edge. Period and high time are measured in source half-periods. The bench samples the output a quarter period after every rising and every falling edge, so a falling-edge transition of an odd ratio is seen at the next falling-edge sample. Every measurement begins at an observed rising transition, so the bench never counts a period before it has started. Under the zero code and under reset, the outputs are sampled after the next falling edge, once the falling-edge register has also been cleared.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  typedef enum logic [1:0] {
    DIV_OFF  = 2'd0,
    DIV_EVEN = 2'd1,
    DIV_ODD  = 2'd2
  } div_mode_e;

  // Ratio N = code + 1, so an odd code gives an even ratio.
  function automatic div_mode_e decode_mode(input logic [3:0] code);
    if (code == 4'd0)   return DIV_OFF;
    else if (code[0])   return DIV_EVEN;
    else                return DIV_ODD;
  endfunction

endpackage

// File: rtl/clkdiv_code_reg.sv
module clkdiv_code_reg
  import clkdiv_pkg::*;
#(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  input  logic             terminal,
  output logic [SEL_W-1:0] code_q,
  output div_mode_e        mode_q,
  output logic             run,
  output logic             load
);

  localparam int PAD_W = (SEL_W < 4) ? 4 - SEL_W : 0;

  logic [3:0] sel4;

  generate
    if (SEL_W >= 4) begin : g_wide
      assign sel4 = {sel[SEL_W-1:1] != '0 ? 3'b111 : 3'b000, sel[0]} & {3'b111, 1'b1};
    end else begin : g_narrow
      assign sel4 = {{PAD_W{1'b0}}, sel};
    end
  endgenerate

  assign run  = (mode_q != DIV_OFF);
  assign load = terminal || !run;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      mode_q <= DIV_OFF;
    end else if (load) begin
      code_q <= sel;
      mode_q <= decode_mode(sel4);
    end
  end

  // R6: the active code never moves except at a load point
  a_r6_code_hold: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(code_q));

endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter #(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             run,
  input  logic [SEL_W-1:0] code_q,
  input  logic [SEL_W-1:0] next_code,
  output logic             hi,
  output logic             terminal
);

  localparam int CW = SEL_W + 1;

  logic [SEL_W-1:0] cnt;
  logic [CW-1:0]    cnt_inc;
  logic [CW-1:0]    half_len;

  // High phase on rising edges lasts floor(N/2) cycles, N = code + 1.
  assign half_len = ({1'b0, code_q} + {{SEL_W{1'b0}}, 1'b1}) >> 1;
  assign cnt_inc  = {1'b0, cnt} + {{SEL_W{1'b0}}, 1'b1};
  assign terminal = run && (cnt == code_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      hi  <= 1'b0;
    end else if (load) begin
      cnt <= '0;
      hi  <= (next_code != '0);
    end else begin
      cnt <= cnt_inc[SEL_W-1:0];
      hi  <= (cnt_inc < half_len);
    end
  end

  // R1: the count never passes the active terminal value
  a_r1_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt <= code_q));

  // R2: a high phase only starts at the beginning of a period
  a_r2_rise_at_start: assert property (@(posedge clk) disable iff (rst)
    $rose(hi) |-> (cnt == '0));

endmodule

// File: rtl/clkdiv_halfcycle.sv
module clkdiv_halfcycle #(
  parameter int COPIES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hi,
  input  logic              odd,
  output logic [COPIES-1:0] clk_out
);

  logic neg_q;
  logic merged;

  always_ff @(negedge clk) begin
    if (rst) neg_q <= 1'b0;
    else     neg_q <= hi;
  end

  assign merged = hi | (odd & neg_q);

  generate
    for (genvar i = 0; i < COPIES; i++) begin : g_copy
      assign clk_out[i] = merged;
    end
  endgenerate

  // R3: the falling-edge copy trails the rising-edge phase by half a cycle
  a_r3_half_lag: assert property (@(posedge clk) disable iff (rst)
    neg_q == hi);

endmodule

// File: rtl/clkdiv_oddeven.sv
module clkdiv_oddeven
  import clkdiv_pkg::*;
#(
  parameter int SEL_W = 4
) (
  input  logic             clk_in,
  input  logic             rst,
  input  logic [SEL_W-1:0] div_sel,
  output logic             clk_out_a,
  output logic             clk_out_b,
  output logic             out_en
);

  localparam int COPIES = 2;

  logic [SEL_W-1:0]  code_q;
  div_mode_e         mode_q;
  logic              run;
  logic              load;
  logic              terminal;
  logic              hi;
  logic [COPIES-1:0] outs;

  clkdiv_code_reg #(.SEL_W(SEL_W)) u_code (
    .clk      (clk_in),
    .rst      (rst),
    .sel      (div_sel),
    .terminal (terminal),
    .code_q   (code_q),
    .mode_q   (mode_q),
    .run      (run),
    .load     (load)
  );

  clkdiv_counter #(.SEL_W(SEL_W)) u_cnt (
    .clk       (clk_in),
    .rst       (rst),
    .load      (load),
    .run       (run),
    .code_q    (code_q),
    .next_code (div_sel),
    .hi        (hi),
    .terminal  (terminal)
  );

  clkdiv_halfcycle #(.COPIES(COPIES)) u_fix (
    .clk     (clk_in),
    .rst     (rst),
    .hi      (hi),
    .odd     (mode_q == DIV_ODD),
    .clk_out (outs)
  );

  assign clk_out_a = outs[0];
  assign clk_out_b = outs[1];
  assign out_en    = run;

  // R4: no output activity while stopped
  a_r4_off_low: assert property (@(posedge clk_in) disable iff (rst)
    !out_en |-> (outs == '0));

  // R9: starting from the stopped state raises the output immediately
  a_r9_start_high: assert property (@(posedge clk_in) disable iff (rst)
    $rose(out_en) |-> clk_out_a);

endmodule

// File: tb/clkdiv_oddeven_tb.sv
module clkdiv_oddeven_tb;

  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] sel;
  logic       a, b, en;

  always #10 clk = ~clk;

  clkdiv_oddeven #(.SEL_W(4)) u_dut (
    .clk_in    (clk),
    .rst       (rst),
    .div_sel   (sel),
    .clk_out_a (a),
    .clk_out_b (b),
    .out_en    (en)
  );

  int tests = 0;
  int fails = 0;
  int mism  = 0;

  // code, expected high half-periods (N), expected period half-periods (2N)
  localparam int NV = 8;
  localparam int TBL [0:NV-1][0:2] = '{
    '{1, 2, 4},   '{2, 3, 6},   '{3, 4, 8},   '{4, 5, 10},
    '{7, 8, 16},  '{8, 9, 18},  '{14, 15, 30}, '{15, 16, 32}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(output logic v);
    @(clk);
    #5;
    v = a;
    if (a !== b) mism++;
  endtask

  task automatic wait_rise(output bit ok);
    logic v;
    int n;
    ok = 1'b0;
    n = 0;
    step(v);
    while (v !== 1'b0 && n < 100) begin step(v); n++; end
    while (v !== 1'b1 && n < 200) begin step(v); n++; end
    ok = (v === 1'b1);
  endtask

  // Starts right after a rising-transition sample; ends on the next one.
  task automatic count_period(output int hi_h, output int lo_h);
    logic v;
    hi_h = 1;
    lo_h = 0;
    step(v);
    while (v === 1'b1 && hi_h < 100) begin hi_h++; step(v); end
    while (v !== 1'b1 && lo_h < 100) begin lo_h++; step(v); end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int hi_h, lo_h, seen;
    bit ok;
    logic v;

    rst = 1'b1;
    sel = 4'd3;
    repeat (3) @(posedge clk);
    @(negedge clk); #5;
    chk(a == 1'b0 && b == 1'b0, "R8 outputs low in reset", int'(a), 0);
    chk(en == 1'b0, "R8 out_en low in reset", int'(en), 0);

    @(posedge clk); #5;
    rst = 1'b0;
    @(posedge clk); #5;
    chk(en == 1'b1, "R9 enable after reset release", int'(en), 1);
    chk(a == 1'b1, "R9 output high after first load", int'(a), 1);

    for (int i = 0; i < NV; i++) begin
      sel = 4'(TBL[i][0]);
      wait_rise(ok);
      chk(ok, "R1 rise seen", int'(ok), 1);
      count_period(hi_h, lo_h);
      chk(hi_h + lo_h == TBL[i][2], "R1 period half-cycles", hi_h + lo_h, TBL[i][2]);
      chk(hi_h == TBL[i][1], (TBL[i][0] % 2 == 1) ? "R2 even high time" : "R3 odd high time",
          hi_h, TBL[i][1]);
      chk(en == 1'b1, "R5 out_en while running", int'(en), 1);
    end

    // R6: change the code just after a period starts
    sel = 4'd15;
    wait_rise(ok);
    count_period(hi_h, lo_h);
    sel = 4'd1;
    count_period(hi_h, lo_h);
    chk(hi_h == 16 && lo_h == 16, "R6 running period kept", hi_h + lo_h, 32);
    count_period(hi_h, lo_h);
    chk(hi_h == 2 && lo_h == 2, "R6 new code after boundary", hi_h + lo_h, 4);

    // R4: zero code parks the output low
    sel = 4'd0;
    repeat (40) step(v);
    chk(en == 1'b0, "R4 out_en low when off", int'(en), 0);
    seen = 0;
    for (int k = 0; k < 40; k++) begin
      step(v);
      if (v !== 1'b0) seen++;
    end
    chk(seen == 0, "R4 no high samples when off", seen, 0);

    // R9: restart from the off state with an odd ratio
    @(posedge clk); #5;
    sel = 4'd4;
    @(negedge clk); #5;
    chk(a == 1'b0, "R9 still low before load", int'(a), 0);
    @(posedge clk); #5;
    chk(a == 1'b1 && en == 1'b1, "R9 high right after load", int'(a), 1);

    // R8: reset in mid run
    repeat (3) @(posedge clk);
    #5;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk); #5;
    chk(a == 1'b0 && b == 1'b0, "R8 outputs cleared by reset", int'(a), 0);
    chk(en == 1'b0, "R8 out_en cleared by reset", int'(en), 0);
    sel = 4'd0;
    @(posedge clk); #5;
    rst = 1'b0;
    repeat (5) @(posedge clk);
    #5;
    chk(en == 1'b0 && a == 1'b0, "R4 stays off with zero code", int'(en), 0);

    chk(mism == 0, "R7 copies identical", mism, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule